// File: doc/BRIEF.md
# Power-Control Register Access Guard

This block sits between a simple single-cycle register bus and a small bank of power-control registers, and decides for every access whether it may proceed. Each request carries three attributes besides its address and data: a user (unprivileged) flag, a non-secure flag and a 2-bit domain identifier. The guard compares them against an access policy word that is itself one of the guarded registers. A granted access completes normally. A refused one gets an error response, leaves every register untouched and returns zero data.

The policy word also holds three sticky lock bits. One freezes the privilege and security allowances. One freezes the domain whitelist. One freezes the 2-bit control-mode field of the mode register. Once set, a lock can only be cleared by reset, so boot code can fix the policy before handing the bus to less trusted software. The remaining registers are plain read/write storage. The response comes back on the clock edge after the request.

Top module: `pwr_guard`

## Requirements
- R1: After reset the policy word reads 0x00000F00: both allowances clear, all locks clear, whitelist 4'hF. The mode register and every plain register read 0, and no response is signalled until a request arrives.
- R2: Each request with `req_valid` high produces exactly one response, with `rsp_valid` high on the cycle after the request. `rsp_valid` is low on every cycle that does not follow a request.
- R3: Policy bit 0 (allow-user): when it is 0, an access with `req_user`=1 is refused. When it is 1, user accesses pass this check.
- R4: Policy bit 1 (allow-non-secure): when it is 0, an access with `req_nonsec`=1 is refused. When it is 1, non-secure accesses pass this check.
- R5: Policy bits 11:8 form a whitelist. Bit 8+d must be 1 for an access carrying domain ID d to be granted. Privilege, security and whitelist must all pass for a grant.
- R6: A refused access returns `rsp_error`=1 with `rsp_rdata`=0, and a refused write modifies no register. A granted access returns `rsp_error`=0. A granted read returns the register contents, and a granted write returns zero data.
- R7: While the settings lock (policy bit 4) is 1, writes leave policy bits 1:0 unchanged, and the other fields of the same write still update. A lock is judged by its value before the write, so a write that sets a lock still updates the field it guards.
- R8: While the list lock (policy bit 12) is 1, writes leave policy bits 11:8 unchanged, and the other fields of the same write still update.
- R9: Address 1 is the mode register: control-mode in bits 1:0, domain assignment in bits 5:4. While the configuration lock (policy bit 20) is 1, writes leave bits 1:0 unchanged, and bits 5:4 still update.
- R10: Each lock bit is set by writing 1 to it. Writing 0 never clears it, and only reset returns it to 0.
- R11: Addresses 0 and 1 hold the policy and mode registers. Every address from 2 up to the top of the address space holds a plain full-width register that reads back exactly what was last written by a granted write.
- R12: Bits of the policy word and the mode register with no defined field read as 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write data |
| req_user | input | 1 | Access comes from unprivileged (user) level |
| req_nonsec | input | 1 | Access comes from the non-secure world |
| req_domain | input | 2 | Domain ID of the requester |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_error | output | 1 | Access was refused |
| rsp_rdata | output | DW | Read data, zero for writes and refusals |

## Verification
The assertions check several properties on every cycle: the one-cycle response timing, zero data on every refusal, and that a refused access leaves the policy and mode state unchanged. They also check that a frozen field never moves while its lock is set, and that no lock bit ever falls outside reset. Other behaviour can only be shown by the bench's scenarios: which attribute combinations are granted, that the unlocked fields of a partly frozen write still update, that reserved bits read zero, and that a reset clears the locks. The bench does this by writing through the bus and reading back under different privilege, security and domain attributes.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

    localparam int DOM_W = 2;
    localparam int WL_W  = 1 << DOM_W;

    // bit positions inside the policy word
    localparam int POL_ALLOW_USER = 0;
    localparam int POL_ALLOW_NS   = 1;
    localparam int POL_LOCK_SET   = 4;
    localparam int POL_WL_LO      = 8;
    localparam int POL_LOCK_LIST  = 12;
    localparam int POL_LOCK_CFG   = 20;
    localparam int POLICY_W       = POL_LOCK_CFG + 1;

    // bit positions inside the mode register
    localparam int MODE_CTRL_LO = 0;
    localparam int MODE_DOM_LO  = 4;
    localparam int MODE_W       = MODE_DOM_LO + 2;

    typedef struct packed {
        logic            allow_user;
        logic            allow_ns;
        logic            lock_set;
        logic            lock_list;
        logic            lock_cfg;
        logic [WL_W-1:0] whitelist;
    } policy_t;

    typedef struct packed {
        logic [1:0] ctrl;
        logic [1:0] dom;
    } mode_t;

    typedef struct packed {
        logic             user;
        logic             nonsec;
        logic [DOM_W-1:0] domain;
    } attr_t;

    typedef enum logic [1:0] {
        SEL_POLICY = 2'd0,
        SEL_MODE   = 2'd1,
        SEL_PLAIN  = 2'd2
    } sel_e;

    function automatic logic [POLICY_W-1:0] pack_policy(policy_t p);
        logic [POLICY_W-1:0] w;
        w = '0;
        w[POL_ALLOW_USER]         = p.allow_user;
        w[POL_ALLOW_NS]           = p.allow_ns;
        w[POL_LOCK_SET]           = p.lock_set;
        w[POL_WL_LO +: WL_W]      = p.whitelist;
        w[POL_LOCK_LIST]          = p.lock_list;
        w[POL_LOCK_CFG]           = p.lock_cfg;
        return w;
    endfunction

    function automatic policy_t unpack_policy(logic [POLICY_W-1:0] w);
        policy_t p;
        p.allow_user = w[POL_ALLOW_USER];
        p.allow_ns   = w[POL_ALLOW_NS];
        p.lock_set   = w[POL_LOCK_SET];
        p.whitelist  = w[POL_WL_LO +: WL_W];
        p.lock_list  = w[POL_LOCK_LIST];
        p.lock_cfg   = w[POL_LOCK_CFG];
        return p;
    endfunction

    function automatic logic [MODE_W-1:0] pack_mode(mode_t m);
        logic [MODE_W-1:0] w;
        w = '0;
        w[MODE_CTRL_LO +: 2] = m.ctrl;
        w[MODE_DOM_LO +: 2]  = m.dom;
        return w;
    endfunction

    function automatic mode_t unpack_mode(logic [MODE_W-1:0] w);
        mode_t m;
        m.ctrl = w[MODE_CTRL_LO +: 2];
        m.dom  = w[MODE_DOM_LO +: 2];
        return m;
    endfunction

endpackage

// File: rtl/pwr_guard_check.sv
module pwr_guard_check
    import pwr_guard_pkg::*;
(
    input  policy_t policy,
    input  attr_t   attr,
    output logic    grant
);
    logic [WL_W-1:0] dom_hit;
    logic            priv_ok;
    logic            sec_ok;

    // one comparator per domain, reduced to a single whitelist verdict
    for (genvar g = 0; g < WL_W; g++) begin : g_dom
        assign dom_hit[g] = policy.whitelist[g] && (attr.domain == DOM_W'(g));
    end

    assign priv_ok = !attr.user   || policy.allow_user;
    assign sec_ok  = !attr.nonsec || policy.allow_ns;
    assign grant   = priv_ok && sec_ok && (|dom_hit);

endmodule

// File: rtl/pwr_guard_policy.sv
module pwr_guard_policy
    import pwr_guard_pkg::*;
#(
    parameter logic [WL_W-1:0] RST_WHITELIST = '1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  policy_t wr_val,
    output policy_t policy_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            policy_q.allow_user <= 1'b0;
            policy_q.allow_ns   <= 1'b0;
            policy_q.lock_set   <= 1'b0;
            policy_q.lock_list  <= 1'b0;
            policy_q.lock_cfg   <= 1'b0;
            policy_q.whitelist  <= RST_WHITELIST;
        end else if (we) begin
            // locks are judged by their value before this write
            if (!policy_q.lock_set) begin
                policy_q.allow_user <= wr_val.allow_user;
                policy_q.allow_ns   <= wr_val.allow_ns;
            end
            if (!policy_q.lock_list) begin
                policy_q.whitelist <= wr_val.whitelist;
            end
            policy_q.lock_set  <= policy_q.lock_set  | wr_val.lock_set;
            policy_q.lock_list <= policy_q.lock_list | wr_val.lock_list;
            policy_q.lock_cfg  <= policy_q.lock_cfg  | wr_val.lock_cfg;
        end
    end

endmodule

// File: rtl/pwr_guard_mode.sv
module pwr_guard_mode
    import pwr_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  logic  cfg_locked,
    input  mode_t wr_val,
    output mode_t mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (we) begin
            if (!cfg_locked) begin
                mode_q.ctrl <= wr_val.ctrl;
            end
            mode_q.dom <= wr_val.dom;
        end
    end

endmodule

// File: rtl/pwr_guard_store.sv
module pwr_guard_store #(
    parameter int AW    = 2,
    parameter int DW    = 32,
    parameter int FIRST = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int NUM_REGS = (1 << AW) - FIRST;

    logic [DW-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && addr == AW'(g + FIRST)) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == AW'(i + FIRST)) rdata = regs[i];
        end
    end

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
    import pwr_guard_pkg::*;
#(
    parameter int              AW            = 2,
    parameter int              DW            = 32,
    parameter logic [WL_W-1:0] RST_WHITELIST = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic             req_user,
    input  logic             req_nonsec,
    input  logic [DOM_W-1:0] req_domain,
    output logic             rsp_valid,
    output logic             rsp_error,
    output logic [DW-1:0]    rsp_rdata
);
    localparam logic [AW-1:0] ADDR_POLICY = AW'(0);
    localparam logic [AW-1:0] ADDR_MODE   = AW'(1);
    localparam int            FIRST_PLAIN = 2;

    attr_t         attr;
    policy_t       policy_q;
    mode_t         mode_q;
    logic          grant;
    sel_e          sel;
    logic          wr_ok;
    logic [DW-1:0] plain_rdata;
    logic [DW-1:0] rd_mux;

    assign attr = '{user: req_user, nonsec: req_nonsec, domain: req_domain};

    pwr_guard_check i_check (
        .policy (policy_q),
        .attr   (attr),
        .grant  (grant)
    );

    always_comb begin
        if (req_addr == ADDR_POLICY)    sel = SEL_POLICY;
        else if (req_addr == ADDR_MODE) sel = SEL_MODE;
        else                            sel = SEL_PLAIN;
    end

    assign wr_ok = req_valid && req_write && grant;

    pwr_guard_policy #(
        .RST_WHITELIST (RST_WHITELIST)
    ) i_policy (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_ok && sel == SEL_POLICY),
        .wr_val   (unpack_policy(req_wdata[POLICY_W-1:0])),
        .policy_q (policy_q)
    );

    pwr_guard_mode i_mode (
        .clk        (clk),
        .rst        (rst),
        .we         (wr_ok && sel == SEL_MODE),
        .cfg_locked (policy_q.lock_cfg),
        .wr_val     (unpack_mode(req_wdata[MODE_W-1:0])),
        .mode_q     (mode_q)
    );

    pwr_guard_store #(
        .AW    (AW),
        .DW    (DW),
        .FIRST (FIRST_PLAIN)
    ) i_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok && sel == SEL_PLAIN),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (plain_rdata)
    );

    always_comb begin
        unique case (sel)
            SEL_POLICY: rd_mux = DW'(pack_policy(policy_q));
            SEL_MODE:   rd_mux = DW'(pack_mode(mode_q));
            default:    rd_mux = plain_rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_error <= req_valid && !grant;
            rsp_rdata <= (req_valid && grant && !req_write) ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/pwr_guard_sva.sv
module pwr_guard_sva
    import pwr_guard_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          rsp_valid,
    input logic          rsp_error,
    input logic [DW-1:0] rsp_rdata,
    input policy_t       policy,
    input mode_t         mode
);
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_refused_zero_data_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_error) |-> (rsp_rdata == '0));

    assert_refused_no_change_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_error) |-> ($stable(policy) && $stable(mode)));

    assert_settings_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        policy.lock_set |=> $stable({policy.allow_user, policy.allow_ns}));

    assert_list_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        policy.lock_list |=> $stable(policy.whitelist));

    assert_ctrl_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        policy.lock_cfg |=> $stable(mode.ctrl));

    assert_lock_set_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        policy.lock_set |=> policy.lock_set);

    assert_lock_list_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        policy.lock_list |=> policy.lock_list);

    assert_lock_cfg_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        policy.lock_cfg |=> policy.lock_cfg);

endmodule

bind pwr_guard pwr_guard_sva #(.DW(DW)) i_sva (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_error (rsp_error),
    .rsp_rdata (rsp_rdata),
    .policy    (policy_q),
    .mode      (mode_q)
);

// File: tb/test_pwr_guard.sv
module test_pwr_guard;

    localparam int AW = 2;
    localparam int DW = 32;

    typedef struct {
        logic [DW-1:0] data;
        logic          err;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_user = 1'b0;
    logic          req_nonsec = 1'b0;
    logic [1:0]    req_domain = '0;
    logic          rsp_valid;
    logic          rsp_error;
    logic [DW-1:0] rsp_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    exp_t exp_q[$];

    // reference state built from the requirements
    bit         m_au, m_ans, m_ls, m_ll, m_lc;
    logic [3:0] m_wl;
    logic [1:0] m_ctrl, m_dom;
    logic [DW-1:0] m_plain [2];

    always #4 clk = ~clk;

    pwr_guard #(.AW(AW), .DW(DW)) i_pwr_guard (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_user   (req_user),
        .req_nonsec (req_nonsec),
        .req_domain (req_domain),
        .rsp_valid  (rsp_valid),
        .rsp_error  (rsp_error),
        .rsp_rdata  (rsp_rdata)
    );

    function automatic void model_reset();
        m_au = 0; m_ans = 0; m_ls = 0; m_ll = 0; m_lc = 0;
        m_wl = 4'hF; m_ctrl = 0; m_dom = 0;
        m_plain[0] = '0; m_plain[1] = '0;
    endfunction

    function automatic logic [DW-1:0] model_read(logic [AW-1:0] a);
        logic [DW-1:0] w;
        w = '0;
        if (a == 0) begin
            w[0] = m_au; w[1] = m_ans; w[4] = m_ls;
            w[11:8] = m_wl; w[12] = m_ll; w[20] = m_lc;
        end else if (a == 1) begin
            w[1:0] = m_ctrl; w[5:4] = m_dom;
        end else begin
            w = m_plain[a - 2];
        end
        return w;
    endfunction

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit u, input bit ns, input logic [1:0] dm, input string tag);
        exp_t e;
        bit g;
        g = (!u || m_au) && (!ns || m_ans) && m_wl[dm];
        e.err  = !g;
        e.data = (g && !wr) ? model_read(a) : '0;
        e.tag  = tag;
        if (g && wr) begin
            if (a == 0) begin
                if (!m_ls) begin m_au = d[0]; m_ans = d[1]; end
                if (!m_ll) m_wl = d[11:8];
                m_ls = m_ls | d[4];
                m_ll = m_ll | d[12];
                m_lc = m_lc | d[20];
            end else if (a == 1) begin
                if (!m_lc) m_ctrl = d[1:0];
                m_dom = d[5:4];
            end else begin
                m_plain[a - 2] = d;
            end
        end
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        req_user = u; req_nonsec = ns; req_domain = dm;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0; req_write = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; req_valid = 0;
        repeat (2) @(negedge clk);
        model_reset();
        rst = 0;
        @(negedge clk);
        vectors++;
        if (rsp_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: rsp_valid after reset actual=%b expected=0", rsp_valid);
        end
    endtask

    // monitor: pop and compare every response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R2: response with no request actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_error !== e.err || rsp_rdata !== e.data) begin
                    miscompares++;
                    $display("FAIL %s: actual err=%b data=%h expected err=%b data=%h",
                             e.tag, rsp_error, rsp_rdata, e.err, e.data);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1 reset values
        access(0, 0, 0, 0, 0, 0, "R1 policy reset");
        access(0, 1, 0, 0, 0, 0, "R1 mode reset");
        access(0, 2, 0, 0, 0, 0, "R1 plain reset");
        // R11 plain storage
        access(1, 2, 32'hDEADBEEF, 0, 0, 0, "R11 write");
        access(1, 3, 32'h12345678, 0, 0, 3, "R11 write");
        access(0, 2, 0, 0, 0, 1, "R11 readback");
        access(0, 3, 0, 0, 0, 2, "R11 readback");
        // R3 privilege
        access(0, 2, 0, 1, 0, 0, "R3 user refused");
        access(1, 0, 32'h0000_0F01, 0, 0, 0, "R3 allow user");
        access(0, 2, 0, 1, 0, 0, "R3 user granted");
        // R4 security
        access(0, 3, 0, 0, 1, 0, "R4 nonsec refused");
        access(0, 3, 0, 1, 1, 0, "R4 user nonsec refused");
        access(1, 0, 32'h0000_0F03, 0, 0, 0, "R4 allow nonsec");
        access(0, 3, 0, 1, 1, 0, "R4 nonsec granted");
        // R5 / R6 whitelist and refusals
        access(1, 0, 32'h0000_0503, 0, 0, 0, "R5 whitelist 0,2");
        access(0, 2, 0, 0, 0, 1, "R5 domain1 refused");
        access(1, 2, 32'hAAAA5555, 0, 0, 3, "R6 refused write");
        access(0, 2, 0, 0, 0, 2, "R6 unchanged after refused write");
        access(1, 0, 32'h0000_0F00, 0, 0, 1, "R6 refused policy write");
        access(0, 0, 0, 1, 1, 2, "R5 domain2 granted");
        // R7 settings lock (set in same write as unchanged allowances)
        access(1, 0, 32'h0000_0513, 0, 0, 0, "R7 set settings lock");
        access(1, 0, 32'h0000_0A10, 0, 0, 2, "R7 frozen allowances");
        access(0, 0, 0, 1, 1, 1, "R7 readback");
        access(1, 0, 32'h0000_0A00, 0, 0, 1, "R10 write zero to lock");
        access(0, 0, 0, 0, 0, 3, "R10 lock stays");
        // R8 list lock
        access(1, 0, 32'h0000_1F10, 0, 0, 1, "R8 set list lock");
        access(1, 0, 32'h0000_0000, 0, 0, 1, "R8 frozen whitelist");
        access(0, 0, 0, 0, 0, 0, "R8 readback");
        // R9 configuration lock
        access(1, 1, 32'h0000_0032, 0, 0, 0, "R9 mode write");
        access(0, 1, 0, 0, 0, 0, "R9 mode readback");
        access(1, 0, 32'h0010_1F13, 0, 0, 0, "R9 set cfg lock");
        access(1, 1, 32'h0000_0001, 0, 0, 0, "R9 ctrl frozen");
        access(0, 1, 0, 0, 0, 0, "R9 readback");
        // R12 reserved bits
        access(1, 1, 32'hFFFF_FFFF, 0, 0, 0, "R12 mode all ones");
        access(0, 1, 0, 0, 0, 0, "R12 mode reserved zero");
        access(1, 0, 32'hFFFF_FFFF, 0, 0, 0, "R12 policy all ones");
        access(0, 0, 0, 0, 0, 0, "R12 policy reserved zero");
        idle(3);
        // R10 reset clears locks
        do_reset();
        access(0, 0, 0, 0, 0, 0, "R10 locks cleared by reset");
        access(0, 1, 0, 0, 0, 0, "R1 mode after second reset");
        access(0, 3, 0, 0, 0, 0, "R1 plain after second reset");
        idle(3);
        vectors++;
        if (exp_q.size() != 0) begin
            miscompares++;
            $display("FAIL R2: missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule